// File: doc/BRIEF.md
# TPM Command-Response Buffer Control Registers

This block is the memory-mapped control and status register file for a TPM command-response buffer interface. Host software reaches it through a simple 32-bit register bus. Software uses it in a fixed order. It first claims a locality, then moves the TPM out of idle. It then starts a command whose bytes already sit in a separate data buffer, which is outside this block. Finally it polls until the start bit drops.

Toward the command engine, the block drives a one-cycle start pulse and a one-cycle cancel pulse. It receives a completion strobe that carries an error flag. It also receives a level input that tells whether a trusted environment has been established. The identification word and the buffer address and size words are constants, loaded at reset from parameters.

Only locality 0 can ever be granted. The locality of a write comes from bits [15:12] of the bus address. A start is accepted only when that locality matches the active one and no command is in flight.

Top module: `crb_ctrl_regs`

## Requirements
- R1: After reset the words read as follows: LOC_STATE (byte offset 0x00) = 0x80, plus bit 0 as set by R10; LOC_STS (0x08) = 0; IFACE_ID (0x10) = 0x00025811; IFACE_ID2 (0x14) = VENDOR (default 0x1014); CTRL_STS (0x24) = 0x2; START (0x2C) = 0; CMD_SIZE (0x30) and RSP_SIZE (0x38) = BUF_BYTES; CMD_ADDR (0x34) and RSP_ADDR (0x3C) = BUF_BASE + BUF_OFS. The write-only words LOC_CTRL (0x04), CTRL_REQ (0x20) and CANCEL (0x28) read as 0. Both backend pulses are low.
- R2: A read request with byte offset a[11:0] returns, on bus_rdata one cycle later, the word at a & ~3 shifted right by 8*(a & 3). bus_rdata holds its value when no read is requested.
- R3: Writing exactly 1 to LOC_CTRL sets LOC_STATE bit 1 (assigned) and LOC_STS bit 0 (granted), and clears LOC_STS bit 1 (seized).
- R4: Writing exactly 2 to LOC_CTRL clears both assigned and granted. Every other value, including 4 and 8, changes nothing.
- R5: Writing exactly 1 to CTRL_REQ clears CTRL_STS bit 1 (idle). Writing exactly 2 sets it. Other values change nothing.
- R6: A write of exactly 1 to START is accepted when three conditions hold: locality bits [15:12] are 0, assigned is set, and START bit 0 is clear. An accepted write sets START bit 0 and raises be_start for exactly the next cycle.
- R7: A START write that fails any condition of R6 causes no be_start pulse and does not change START bit 0.
- R8: Writing exactly 1 to CANCEL while START bit 0 is set raises be_cancel for the next cycle. Any other CANCEL write gives no pulse.
- R9: A be_done strobe while START bit 0 is set clears that bit. If be_error is also high, it sets CTRL_STS bit 0 (fatal), which stays set until reset. A be_done strobe while START bit 0 is clear changes nothing.
- R10: LOC_STATE bit 0 reads as the inverse of be_established, sampled in the cycle of the read request.
- R11: Writes to LOC_STATE, LOC_STS, IFACE_ID, IFACE_ID2, CTRL_STS and the four buffer words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Single-cycle bus request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | [15:12] locality, [11:0] byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read request |
| be_start | output | 1 | One-cycle command start pulse to the engine |
| be_cancel | output | 1 | One-cycle cancel pulse to the engine |
| be_done | input | 1 | Command completion strobe |
| be_error | input | 1 | Completion carries an error (qualified by be_done) |
| be_established | input | 1 | Established flag from the engine |

## Verification
Each result falls due a fixed number of cycles after its stimulus. Read data appears one edge after the request. The be_start and be_cancel pulses appear on the edge that takes the write. Register changes caused by a write or by be_done become visible to a read issued in the next cycle. The bench drives every request on a falling edge and samples outputs on the following falling edge. This places each sample exactly one register stage after the edge that takes the request. Every pulse check is made in that cycle, and assertions confirm that the pulse drops on the next edge.

// File: rtl/crb_ctrl_regs.sv
module crb_ctrl_regs #(
  parameter logic [31:0] BUF_BASE  = 32'hFED4_0000,
  parameter logic [31:0] BUF_OFS   = 32'h0000_0080,
  parameter logic [31:0] BUF_BYTES = 32'h0000_0F80,
  parameter logic [15:0] VENDOR    = 16'h1014
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [15:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        be_start,
  output logic        be_cancel,
  input  logic        be_done,
  input  logic        be_error,
  input  logic        be_established
);
  localparam logic [9:0] W_LSTATE = 10'd0;
  localparam logic [9:0] W_LCTRL  = 10'd1;
  localparam logic [9:0] W_LSTS   = 10'd2;
  localparam logic [9:0] W_ID     = 10'd4;
  localparam logic [9:0] W_ID2    = 10'd5;
  localparam logic [9:0] W_REQ    = 10'd8;
  localparam logic [9:0] W_STS    = 10'd9;
  localparam logic [9:0] W_CANCEL = 10'd10;
  localparam logic [9:0] W_START  = 10'd11;
  localparam logic [9:0] W_CSIZE  = 10'd12;
  localparam logic [9:0] W_CADDR  = 10'd13;
  localparam logic [9:0] W_RSIZE  = 10'd14;
  localparam logic [9:0] W_RADDR  = 10'd15;

  localparam logic [3:0] IF_TYPE = 4'd1;
  localparam logic [3:0] IF_VER  = 4'd1;
  localparam logic [1:0] IF_XFER = 2'b11;
  localparam logic [1:0] IF_SEL  = 2'd1;
  localparam logic [31:0] ID_WORD = {8'd0, 5'd0, IF_SEL, 2'd0, 1'b1, 1'b0,
                                     IF_XFER, 1'b0, 1'b0, 1'b0, IF_VER, IF_TYPE};
  localparam logic [31:0] BUF_ADDR = BUF_BASE + BUF_OFS;
  localparam logic [7:0]  NO_LOC   = 8'hFF;

  logic assigned_q, granted_q, seized_q, idle_q, fatal_q, start_q;
  logic [31:0] word;

  wire [9:0]  widx  = bus_addr[11:2];
  wire [1:0]  boff  = bus_addr[1:0];
  wire [3:0]  wloc  = bus_addr[15:12];
  wire        wr    = bus_valid & bus_write;
  wire        rd    = bus_valid & ~bus_write;
  wire        one   = bus_wdata == 32'd1;
  wire        two   = bus_wdata == 32'd2;
  wire [7:0]  active_loc = assigned_q ? 8'h00 : NO_LOC;
  wire        loc_ok  = {4'd0, wloc} == active_loc;
  wire        start_ok  = wr && widx == W_START && one && !start_q && loc_ok;
  wire        cancel_ok = wr && widx == W_CANCEL && one && start_q;
  wire        finish    = be_done && start_q;

  always_comb begin
    case (widx)
      W_LSTATE: word = {24'd0, 1'b1, 2'd0, 3'd0, assigned_q, ~be_established};
      W_LSTS:   word = {30'd0, seized_q, granted_q};
      W_ID:     word = ID_WORD;
      W_ID2:    word = {16'd0, VENDOR};
      W_STS:    word = {30'd0, idle_q, fatal_q};
      W_START:  word = {31'd0, start_q};
      W_CSIZE:  word = BUF_BYTES;
      W_CADDR:  word = BUF_ADDR;
      W_RSIZE:  word = BUF_BYTES;
      W_RADDR:  word = BUF_ADDR;
      default:  word = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= 32'd0;
    else if (rd) bus_rdata <= word >> {boff, 3'b000};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      assigned_q <= 1'b0;
      granted_q  <= 1'b0;
      seized_q   <= 1'b0;
    end else if (wr && widx == W_LCTRL) begin
      if (one) begin
        assigned_q <= 1'b1;
        granted_q  <= 1'b1;
        seized_q   <= 1'b0;
      end else if (two) begin
        assigned_q <= 1'b0;
        granted_q  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_q <= 1'b1;
    else if (wr && widx == W_REQ) begin
      if (one) idle_q <= 1'b0;
      else if (two) idle_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q   <= 1'b0;
      fatal_q   <= 1'b0;
      be_start  <= 1'b0;
      be_cancel <= 1'b0;
    end else begin
      be_start  <= start_ok;
      be_cancel <= cancel_ok;
      if (start_ok) start_q <= 1'b1;
      else if (finish) start_q <= 1'b0;
      if (finish && be_error) fatal_q <= 1'b1;
    end
  end
endmodule

module crb_ctrl_regs_chk (
  input logic clk,
  input logic rst_n,
  input logic be_start,
  input logic be_cancel,
  input logic be_done,
  input logic start_q,
  input logic fatal_q,
  input logic assigned_q
);
  AST_START_ONE_CYCLE:  assert property (@(posedge clk) disable iff (!rst_n) be_start |=> !be_start); // R6
  AST_START_NEEDS_LOC:  assert property (@(posedge clk) disable iff (!rst_n) be_start |-> $past(assigned_q) && start_q); // R6
  AST_START_FROM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) be_start |-> !$past(start_q)); // R7
  AST_NO_RESTART:       assert property (@(posedge clk) disable iff (!rst_n) (start_q && !be_done) |=> !be_start); // R7
  AST_CANCEL_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n) be_cancel |-> $past(start_q)); // R8
  AST_DONE_CLEARS:      assert property (@(posedge clk) disable iff (!rst_n) (be_done && start_q) |=> !start_q); // R9
  AST_FATAL_STICKY:     assert property (@(posedge clk) disable iff (!rst_n) fatal_q |=> fatal_q); // R9
endmodule

bind crb_ctrl_regs crb_ctrl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .be_start(be_start), .be_cancel(be_cancel),
  .be_done(be_done), .start_q(start_q), .fatal_q(fatal_q), .assigned_q(assigned_q)
);

// File: tb/crb_ctrl_regs_test.sv
module crb_ctrl_regs_test;
  localparam logic [31:0] BASE  = 32'hFED4_0000;
  localparam logic [31:0] OFS   = 32'h0000_0080;
  localparam logic [31:0] BYTES = 32'h0000_0F80;
  localparam logic [15:0] VEND  = 16'h1014;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [15:0] bus_addr = 16'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic be_start, be_cancel;
  logic be_done = 1'b0, be_error = 1'b0, be_established = 1'b1;

  int checks = 0, errors = 0;
  logic e_asg = 0, e_grant = 0, e_idle = 1, e_fatal = 0, e_start = 0;

  always #5 clk = ~clk;

  crb_ctrl_regs #(.BUF_BASE(BASE), .BUF_OFS(OFS), .BUF_BYTES(BYTES), .VENDOR(VEND)) uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .be_start(be_start), .be_cancel(be_cancel), .be_done(be_done),
    .be_error(be_error), .be_established(be_established));

  function automatic logic [31:0] exp_word(input logic [11:0] ofs);
    case (ofs)
      12'h000: return {24'd0, 1'b1, 5'd0, e_asg, ~be_established};
      12'h008: return {31'd0, e_grant};
      12'h010: return 32'h0002_5811;
      12'h014: return {16'd0, VEND};
      12'h024: return {30'd0, e_idle, e_fatal};
      12'h02C: return {31'd0, e_start};
      12'h030, 12'h038: return BYTES;
      12'h034, 12'h03C: return BASE + OFS;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] loc, input logic [11:0] ofs, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = {loc, ofs}; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [11:0] ofs, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = {4'd0, ofs};
    @(negedge clk);
    d = bus_rdata;
    bus_valid = 0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] ofs);
    logic [31:0] d;
    logic [31:0] e;
    e = exp_word({ofs[11:2], 2'b00}) >> (8 * ofs[1:0]);
    rd(ofs, d);
    check(req, d, e);
  endtask

  task automatic done(input logic err);
    @(negedge clk);
    be_done = 1; be_error = err;
    @(negedge clk);
    be_done = 0; be_error = 0;
  endtask

  task automatic all_words(input string req);
    for (int w = 0; w < 16; w++) rd_chk(req, 12'(w * 4));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 start pulse at reset", {31'd0, be_start}, 32'd0);
    check("R1 cancel pulse at reset", {31'd0, be_cancel}, 32'd0);
    check("R1 rdata at reset", bus_rdata, 32'd0);
    all_words("R1 reset word");

    // R2: every byte offset of every word
    for (int w = 0; w < 16; w++)
      for (int b = 1; b < 4; b++) rd_chk("R2 byte read", 12'(w * 4 + b));
    rd(12'h010, d);
    repeat (3) @(negedge clk);
    check("R2 rdata holds", bus_rdata, 32'h0002_5811);

    // R10
    be_established = 0; rd_chk("R10 established low", 12'h000);
    be_established = 1; rd_chk("R10 established high", 12'h000);

    // R3 / R4: sweep LOC_CTRL values from both states
    for (int s = 0; s < 2; s++)
      for (int v = 0; v < 16; v++) begin
        wr(0, 12'h004, s[0] ? 32'd1 : 32'd2);
        e_asg = s[0]; e_grant = s[0];
        wr(0, 12'h004, 32'(v));
        if (v == 1) begin e_asg = 1; e_grant = 1; end
        else if (v == 2) begin e_asg = 0; e_grant = 0; end
        rd_chk(v == 1 ? "R3 loc state" : "R4 loc state", 12'h000);
        rd_chk(v == 1 ? "R3 loc status" : "R4 loc status", 12'h008);
      end

    // R5: sweep CTRL_REQ values from both idle states
    for (int s = 0; s < 2; s++)
      for (int v = 0; v < 8; v++) begin
        wr(0, 12'h020, s[0] ? 32'd2 : 32'd1);
        e_idle = s[0];
        wr(0, 12'h020, 32'(v));
        if (v == 1) e_idle = 0; else if (v == 2) e_idle = 1;
        rd_chk("R5 idle", 12'h024);
      end

    // R7: start while unassigned
    wr(0, 12'h004, 32'd2); e_asg = 0; e_grant = 0;
    wr(0, 12'h02C, 32'd1);
    check("R7 unassigned start pulse", {31'd0, be_start}, 32'd0);
    rd_chk("R7 unassigned start bit", 12'h02C);
    wr(0, 12'h004, 32'd1); e_asg = 1; e_grant = 1;
    for (int l = 1; l < 16; l++) begin
      wr(4'(l), 12'h02C, 32'd1);
      check("R7 wrong locality pulse", {31'd0, be_start}, 32'd0);
    end
    for (int v = 0; v < 8; v++)
      if (v != 1) begin
        wr(0, 12'h02C, 32'(v));
        check("R7 wrong value pulse", {31'd0, be_start}, 32'd0);
      end
    rd_chk("R7 start bit still clear", 12'h02C);

    // R8 before start: no cancel
    wr(0, 12'h028, 32'd1);
    check("R8 cancel while idle", {31'd0, be_cancel}, 32'd0);

    // R6: accepted start
    wr(0, 12'h02C, 32'd1); e_start = 1;
    check("R6 start pulse", {31'd0, be_start}, 32'd1);
    @(negedge clk);
    check("R6 start pulse one cycle", {31'd0, be_start}, 32'd0);
    rd_chk("R6 start bit", 12'h02C);
    wr(0, 12'h02C, 32'd1);
    check("R7 busy start pulse", {31'd0, be_start}, 32'd0);

    // R8: cancel while in flight
    wr(0, 12'h028, 32'd2);
    check("R8 cancel wrong value", {31'd0, be_cancel}, 32'd0);
    wr(0, 12'h028, 32'd1);
    check("R8 cancel pulse", {31'd0, be_cancel}, 32'd1);
    @(negedge clk);
    check("R8 cancel one cycle", {31'd0, be_cancel}, 32'd0);

    // R9
    done(0); e_start = 0;
    rd_chk("R9 done clears start", 12'h02C);
    rd_chk("R9 no error no fatal", 12'h024);
    wr(0, 12'h028, 32'd1);
    check("R8 cancel after done", {31'd0, be_cancel}, 32'd0);
    done(1);
    rd_chk("R9 stray done ignored", 12'h024);
    wr(0, 12'h02C, 32'd1); e_start = 1;
    check("R6 second start pulse", {31'd0, be_start}, 32'd1);
    done(1); e_start = 0; e_fatal = 1;
    rd_chk("R9 error sets fatal", 12'h024);
    rd_chk("R9 start cleared on error", 12'h02C);
    wr(0, 12'h020, 32'd2); e_idle = 1;
    rd_chk("R9 fatal sticky", 12'h024);

    // R11: read-only words ignore writes
    for (int w = 0; w < 16; w++) begin
      logic [11:0] o;
      o = 12'(w * 4);
      if (o == 12'h000 || o == 12'h008 || o == 12'h010 || o == 12'h014 || o == 12'h024 ||
          (o >= 12'h030 && o <= 12'h03C)) begin
        wr(0, o, 32'hFFFF_FFFF);
        wr(0, o, 32'd1);
        wr(0, o, 32'd2);
        rd_chk("R11 read-only word", o);
      end
    end
    all_words("R11 final state");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule